// File: doc/BRIEF.md
# Token Conservation Signature Checker

This block watches the flow of coherence tokens between a set of nodes and confirms, one checking interval at a time, that no token was created, lost or credited to the wrong block. Each node keeps a logical clock. The clock moves forward on every send and every receive, and it jumps past any newer timestamp that arrives in a message. Every outgoing message is stamped with the sender's clock. Both ends of a transfer fold the same product, token count times that stamp, into a per-node signature. The receiving end adds the product and the sending end subtracts it. A second signature, built in the same way from block address times token count, catches tokens that land on the wrong block.

All arithmetic wraps at 2^SIG_W, so each signature has a fixed width. An interval ends with a close pulse. The current interval's parity then flips, and the signatures of the closing interval are frozen for a grace window. During that window, receives still carrying the old parity are counted. After the window, the frozen signatures of all nodes are summed, and a non-zero total of either kind raises an error flag. An old-parity receive that arrives after the window is reported as a late fault and is not counted. Every receive is also checked against the per-block token limit.

Top module: `tok_sig_checker`

## Requirements
- R1: A send with no receive on the same node in that cycle stamps the message with the node's logical time plus one, shown combinationally on `snd_ts`. That value becomes the node's new time. A node with no event keeps its time.
- R2: A receive sets the node's time to the message timestamp plus one when the timestamp is greater than the local time, and to the local time plus one otherwise. When a send and a receive occur in the same cycle, the receive rule is applied first, then one more is added, and that result is the send's stamp.
- R3: A receive adds count × received timestamp to the node's token signature, and a send subtracts count × its stamp, both modulo 2^SIG_W. At the verdict, `tok_err` is 1 exactly when the sum of all nodes' signatures for the closed interval is non-zero.
- R4: The address signature adds address × count on receive and subtracts it on send, modulo 2^SIG_W. `adr_err` is 1 exactly when its interval sum over all nodes is non-zero.
- R5: `snd_ep` gives the parity of the open interval. It is 0 after reset and flips on the clock edge that accepts a close. A send in the close cycle belongs to the closing interval. A receive belongs to the open interval when its `rcv_ep` equals `snd_ep`; otherwise it belongs to the closing interval.
- R6: Old-parity receives are counted on the GRACE edges that follow the close edge. `verdict_v` is high for exactly one cycle, starting after edge GRACE+1 counted from the close edge.
- R7: An old-parity receive outside the grace window pulses that node's `late_err` bit for one cycle after the edge. It contributes to no signature.
- R8: A close requested while a closed interval is still awaiting its verdict is ignored. The parity does not flip and no extra verdict is produced.
- R9: A receive whose `rcv_held + rcv_cnt` exceeds TOK_MAX pulses that node's `over_err` bit for one cycle.
- R10: After reset, every clock is 0, `snd_ep` is 0, and `verdict_v`, `tok_err`, `adr_err`, `late_err` and `over_err` are 0.
- R11: `tok_err` and `adr_err` hold their values until the next verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intv_close | input | 1 | Request to close the open interval |
| snd_v | input | NODES | Per-node send event |
| snd_cnt | input | NODES×CNT_W | Tokens sent |
| snd_addr | input | NODES×ADDR_W | Block address of the send |
| snd_ts | output | NODES×TS_W | Timestamp to put in the outgoing message |
| snd_ep | output | 1 | Parity of the open interval, carried in messages |
| rcv_v | input | NODES | Per-node receive event |
| rcv_cnt | input | NODES×CNT_W | Tokens received |
| rcv_addr | input | NODES×ADDR_W | Block address of the receive |
| rcv_ts | input | NODES×TS_W | Sender timestamp carried by the message |
| rcv_ep | input | NODES | Interval parity carried by the message |
| rcv_held | input | NODES×CNT_W | Tokens the receiver already holds for that block |
| verdict_v | output | 1 | One-cycle pulse when interval flags are updated |
| tok_err | output | 1 | Token signature sum non-zero |
| adr_err | output | 1 | Address signature sum non-zero |
| late_err | output | NODES | Old-parity receive after the grace window |
| over_err | output | NODES | Token limit exceeded on a receive |

## Verification
The bench goes after the grace boundary. An old message delivered on the last counted edge must leave a clean verdict. The same message one edge later must be flagged late and produce a token error. A design with an off-by-one window would swap those two outcomes. A close issued during the grace window is checked to move neither the parity nor the verdict time; a design that honoured it would double-flip the parity seen in later stamps. Other targets are same-cycle send and receive, a receive timestamp below and above the local time, a corrupted address that must trip only the address signature, and the exact token-limit edge. A design that mis-ordered the clock rules would produce stamps that are off by one.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // Phase of the interval controller.
  typedef enum logic {
    PH_RUN   = 1'b0,
    PH_DRAIN = 1'b1
  } phase_t;
endpackage

// File: rtl/tsc_rst_sync.sv
module tsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/tsc_lclock.sv
module tsc_lclock #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snd_v,
  input  logic            rcv_v,
  input  logic [TS_W-1:0] rcv_ts,
  output logic [TS_W-1:0] stamp,
  output logic [TS_W-1:0] now
);
  logic [TS_W-1:0] time_q, base, time_d;
  logic            tick_en;

  always_comb begin
    base = time_q;
    if (rcv_v) begin
      if (rcv_ts > time_q) base = rcv_ts + TS_W'(1);
      else                 base = time_q + TS_W'(1);
    end
    time_d  = base + TS_W'(snd_v);
    tick_en = snd_v | rcv_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (tick_en) time_q <= time_d;
  end

  assign stamp = time_d;
  assign now   = time_q;
endmodule

// File: rtl/tsc_interval_ctl.sv
module tsc_interval_ctl
  import tsc_pkg::*;
#(
  parameter int GRACE = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic close_req,
  output logic ep,
  output logic roll,
  output logic grace_open,
  output logic judge
);
  localparam int GW = $clog2(GRACE + 1) + 1;

  phase_t        ph_q, ph_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          ep_q, ep_d;
  logic          ctl_en;

  always_comb begin
    roll       = close_req && (ph_q == PH_RUN);
    judge      = (ph_q == PH_DRAIN) && (gcnt_q == '0);
    grace_open = (ph_q == PH_DRAIN) && (gcnt_q != '0);
    ph_d       = ph_q;
    gcnt_d     = gcnt_q;
    ep_d       = ep_q;
    if (roll) begin
      ph_d   = PH_DRAIN;
      gcnt_d = GW'(GRACE);
      ep_d   = ~ep_q;
    end else if (ph_q == PH_DRAIN) begin
      if (gcnt_q == '0) ph_d   = PH_RUN;
      else              gcnt_d = gcnt_q - GW'(1);
    end
    ctl_en = roll | (ph_q == PH_DRAIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_RUN;
      gcnt_q <= '0;
      ep_q   <= 1'b0;
    end else if (ctl_en) begin
      ph_q   <= ph_d;
      gcnt_q <= gcnt_d;
      ep_q   <= ep_d;
    end
  end

  assign ep = ep_q;
endmodule

// File: rtl/tsc_sig_acc.sv
module tsc_sig_acc #(
  parameter int CNT_W   = 4,
  parameter int TS_W    = 16,
  parameter int ADDR_W  = 12,
  parameter int SIG_W   = 16,
  parameter int TOK_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snd_v,
  input  logic [CNT_W-1:0]  snd_cnt,
  input  logic [TS_W-1:0]   snd_stamp,
  input  logic [ADDR_W-1:0] snd_addr,
  input  logic              rcv_v,
  input  logic [CNT_W-1:0]  rcv_cnt,
  input  logic [TS_W-1:0]   rcv_ts,
  input  logic [ADDR_W-1:0] rcv_addr,
  input  logic              rcv_old,
  input  logic [CNT_W-1:0]  rcv_held,
  input  logic              grace_open,
  input  logic              roll,
  output logic [SIG_W-1:0]  old_tok,
  output logic [SIG_W-1:0]  old_adr,
  output logic              late,
  output logic              over
);
  logic [SIG_W-1:0] st, sa, rt, ra, dtok, dadr;
  logic [SIG_W-1:0] cur_tok_q, cur_tok_d, cur_adr_q, cur_adr_d;
  logic [SIG_W-1:0] old_tok_q, old_tok_d, old_adr_q, old_adr_d;
  logic             old_in, cur_en, old_en, late_d, over_d;
  logic [CNT_W:0]   fill;

  always_comb begin
    // Weighted terms, reduced modulo 2^SIG_W by operand sizing.
    st = SIG_W'(snd_cnt) * SIG_W'(snd_stamp);
    sa = SIG_W'(snd_addr) * SIG_W'(snd_cnt);
    rt = SIG_W'(rcv_cnt) * SIG_W'(rcv_ts);
    ra = SIG_W'(rcv_addr) * SIG_W'(rcv_cnt);

    dtok = '0;
    dadr = '0;
    if (snd_v) begin
      dtok = dtok - st;
      dadr = dadr - sa;
    end
    if (rcv_v && !rcv_old) begin
      dtok = dtok + rt;
      dadr = dadr + ra;
    end

    old_in = rcv_v && rcv_old && grace_open;
    if (roll) begin
      old_tok_d = cur_tok_q + dtok;
      old_adr_d = cur_adr_q + dadr;
      cur_tok_d = '0;
      cur_adr_d = '0;
    end else begin
      cur_tok_d = cur_tok_q + dtok;
      cur_adr_d = cur_adr_q + dadr;
      old_tok_d = old_in ? (old_tok_q + rt) : old_tok_q;
      old_adr_d = old_in ? (old_adr_q + ra) : old_adr_q;
    end
    cur_en = roll | snd_v | rcv_v;
    old_en = roll | old_in;

    late_d = rcv_v && rcv_old && !grace_open;
    fill   = {1'b0, rcv_held} + {1'b0, rcv_cnt};
    over_d = rcv_v && (fill > (CNT_W+1)'(TOK_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_tok_q <= '0;
      cur_adr_q <= '0;
    end else if (cur_en) begin
      cur_tok_q <= cur_tok_d;
      cur_adr_q <= cur_adr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_tok_q <= '0;
      old_adr_q <= '0;
    end else if (old_en) begin
      old_tok_q <= old_tok_d;
      old_adr_q <= old_adr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late <= 1'b0;
      over <= 1'b0;
    end else begin
      late <= late_d;
      over <= over_d;
    end
  end

  assign old_tok = old_tok_q;
  assign old_adr = old_adr_q;
endmodule

// File: rtl/tsc_reduce.sv
module tsc_reduce #(
  parameter int NODES = 4,
  parameter int SIG_W = 16
) (
  input  logic [NODES-1:0][SIG_W-1:0] part_tok,
  input  logic [NODES-1:0][SIG_W-1:0] part_adr,
  output logic [SIG_W-1:0]            sum_tok,
  output logic [SIG_W-1:0]            sum_adr
);
  always_comb begin
    sum_tok = '0;
    sum_adr = '0;
    for (int i = 0; i < NODES; i++) begin
      sum_tok = sum_tok + part_tok[i];
      sum_adr = sum_adr + part_adr[i];
    end
  end
endmodule

// File: rtl/tok_sig_checker.sv
module tok_sig_checker #(
  parameter int NODES   = 4,
  parameter int TOK_MAX = 8,
  parameter int TS_W    = 16,
  parameter int ADDR_W  = 12,
  parameter int SIG_W   = 16,
  parameter int GRACE   = 6,
  localparam int CNT_W  = $clog2(TOK_MAX + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         intv_close,
  input  logic [NODES-1:0]             snd_v,
  input  logic [NODES-1:0][CNT_W-1:0]  snd_cnt,
  input  logic [NODES-1:0][ADDR_W-1:0] snd_addr,
  output logic [NODES-1:0][TS_W-1:0]   snd_ts,
  output logic                         snd_ep,
  input  logic [NODES-1:0]             rcv_v,
  input  logic [NODES-1:0][CNT_W-1:0]  rcv_cnt,
  input  logic [NODES-1:0][ADDR_W-1:0] rcv_addr,
  input  logic [NODES-1:0][TS_W-1:0]   rcv_ts,
  input  logic [NODES-1:0]             rcv_ep,
  input  logic [NODES-1:0][CNT_W-1:0]  rcv_held,
  output logic                         verdict_v,
  output logic                         tok_err,
  output logic                         adr_err,
  output logic [NODES-1:0]             late_err,
  output logic [NODES-1:0]             over_err
);
  logic                         rst_ns;
  logic                         ep_q, roll, grace_open, judge;
  logic [NODES-1:0][TS_W-1:0]   node_time;
  logic [NODES-1:0][SIG_W-1:0]  part_tok, part_adr;
  logic [SIG_W-1:0]             sum_tok, sum_adr;
  logic                         verd_q, verd_d, tok_q, tok_d, adr_q, adr_d;

  tsc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  tsc_interval_ctl #(.GRACE(GRACE)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_ns),
    .close_req  (intv_close),
    .ep         (ep_q),
    .roll       (roll),
    .grace_open (grace_open),
    .judge      (judge)
  );

  for (genvar g = 0; g < NODES; g++) begin : gen_node
    logic old_g;
    assign old_g = rcv_ep[g] != ep_q;

    tsc_lclock #(.TS_W(TS_W)) u_clk (
      .clk    (clk),
      .rst_n  (rst_ns),
      .snd_v  (snd_v[g]),
      .rcv_v  (rcv_v[g]),
      .rcv_ts (rcv_ts[g]),
      .stamp  (snd_ts[g]),
      .now    (node_time[g])
    );

    tsc_sig_acc #(
      .CNT_W(CNT_W), .TS_W(TS_W), .ADDR_W(ADDR_W),
      .SIG_W(SIG_W), .TOK_MAX(TOK_MAX)
    ) u_acc (
      .clk        (clk),
      .rst_n      (rst_ns),
      .snd_v      (snd_v[g]),
      .snd_cnt    (snd_cnt[g]),
      .snd_stamp  (snd_ts[g]),
      .snd_addr   (snd_addr[g]),
      .rcv_v      (rcv_v[g]),
      .rcv_cnt    (rcv_cnt[g]),
      .rcv_ts     (rcv_ts[g]),
      .rcv_addr   (rcv_addr[g]),
      .rcv_old    (old_g),
      .rcv_held   (rcv_held[g]),
      .grace_open (grace_open),
      .roll       (roll),
      .old_tok    (part_tok[g]),
      .old_adr    (part_adr[g]),
      .late       (late_err[g]),
      .over       (over_err[g])
    );
  end

  tsc_reduce #(.NODES(NODES), .SIG_W(SIG_W)) u_red (
    .part_tok (part_tok),
    .part_adr (part_adr),
    .sum_tok  (sum_tok),
    .sum_adr  (sum_adr)
  );

  always_comb begin
    verd_d = judge;
    tok_d  = judge ? (sum_tok != '0) : tok_q;
    adr_d  = judge ? (sum_adr != '0) : adr_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      verd_q <= 1'b0;
      tok_q  <= 1'b0;
      adr_q  <= 1'b0;
    end else begin
      verd_q <= verd_d;
      tok_q  <= tok_d;
      adr_q  <= adr_d;
    end
  end

  assign verdict_v = verd_q;
  assign tok_err   = tok_q;
  assign adr_err   = adr_q;
  assign snd_ep    = ep_q;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int NODES = 4,
  parameter int TS_W  = 16,
  parameter int GRACE = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       roll,
  input logic                       verdict_v,
  input logic                       tok_err,
  input logic                       adr_err,
  input logic                       snd_ep,
  input logic [NODES-1:0]           snd_v,
  input logic [NODES-1:0]           rcv_v,
  input logic [NODES-1:0][TS_W-1:0] rcv_ts,
  input logic [NODES-1:0][TS_W-1:0] node_time,
  input logic [NODES-1:0]           late_err,
  input logic [NODES-1:0]           over_err
);
  logic [31:0] since_q;
  logic        armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      armed_q <= 1'b0;
    end else if (roll) begin
      since_q <= '0;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      since_q <= since_q + 32'd1;
    end
  end

  a_r6_grace_window: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_v |-> (armed_q && since_q == 32'(GRACE + 1)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_v |=> !verdict_v);

  a_r5_ep_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snd_ep) |-> (armed_q && since_q == 32'd0));

  a_r11_tok_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tok_err) |-> verdict_v);

  a_r11_adr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adr_err) |-> verdict_v);

  for (genvar i = 0; i < NODES; i++) begin : gen_node_chk
    a_r1_send_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_v[i] && !rcv_v[i]) |=> node_time[i] == $past(node_time[i]) + TS_W'(1));

    a_r2_rcv_jump: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_v[i] && !snd_v[i] && rcv_ts[i] > node_time[i])
        |=> node_time[i] == $past(rcv_ts[i]) + TS_W'(1));

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rcv_v[i] && !snd_v[i]) |=> $stable(node_time[i]));

    a_r7_late_cause: assert property (@(posedge clk) disable iff (!rst_n)
      late_err[i] |-> $past(rcv_v[i]));

    a_r9_over_cause: assert property (@(posedge clk) disable iff (!rst_n)
      over_err[i] |-> $past(rcv_v[i]));
  end
endmodule

bind tok_sig_checker tsc_checker #(
  .NODES(NODES), .TS_W(TS_W), .GRACE(GRACE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_ns),
  .roll      (roll),
  .verdict_v (verdict_v),
  .tok_err   (tok_err),
  .adr_err   (adr_err),
  .snd_ep    (snd_ep),
  .snd_v     (snd_v),
  .rcv_v     (rcv_v),
  .rcv_ts    (rcv_ts),
  .node_time (node_time),
  .late_err  (late_err),
  .over_err  (over_err)
);

// File: tb/tok_sig_checker_tb.sv
`timescale 1ns/1ps
module tok_sig_checker_tb;
  localparam int N       = 4;
  localparam int TOK_MAX = 8;
  localparam int TS_W    = 16;
  localparam int ADDR_W  = 12;
  localparam int SIG_W   = 16;
  localparam int GRACE   = 6;
  localparam int CNT_W   = $clog2(TOK_MAX + 1);
  localparam int TS_MASK = (1 << TS_W) - 1;

  typedef struct {
    int s;
    int cnt;
    int addr;
    int ts;
    bit ep;
  } msg_t;

  logic                     clk, rst_n, intv_close;
  logic [N-1:0]             snd_v, rcv_v, rcv_ep;
  logic [N-1:0][CNT_W-1:0]  snd_cnt, rcv_cnt, rcv_held;
  logic [N-1:0][ADDR_W-1:0] snd_addr, rcv_addr;
  logic [N-1:0][TS_W-1:0]   snd_ts, rcv_ts;
  logic                     snd_ep, verdict_v, tok_err, adr_err;
  logic [N-1:0]             late_err, over_err;

  tok_sig_checker #(
    .NODES(N), .TOK_MAX(TOK_MAX), .TS_W(TS_W),
    .ADDR_W(ADDR_W), .SIG_W(SIG_W), .GRACE(GRACE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .intv_close(intv_close),
    .snd_v(snd_v), .snd_cnt(snd_cnt), .snd_addr(snd_addr),
    .snd_ts(snd_ts), .snd_ep(snd_ep),
    .rcv_v(rcv_v), .rcv_cnt(rcv_cnt), .rcv_addr(rcv_addr),
    .rcv_ts(rcv_ts), .rcv_ep(rcv_ep), .rcv_held(rcv_held),
    .verdict_v(verdict_v), .tok_err(tok_err), .adr_err(adr_err),
    .late_err(late_err), .over_err(over_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int               checks = 0;
  int               errs   = 0;
  int               mclk[N];
  bit               mep;
  bit               closing;
  int               since;
  logic [SIG_W-1:0] tc, ac, to_sig, ao_sig;
  bit               last_tok;

  function automatic logic [SIG_W-1:0] wt(input int unsigned a, input int unsigned b);
    int unsigned p;
    p = a * b;
    return p[SIG_W-1:0];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    intv_close = 1'b0;
    snd_v = '0; snd_cnt = '0; snd_addr = '0;
    rcv_v = '0; rcv_cnt = '0; rcv_addr = '0; rcv_ts = '0;
    rcv_ep = '0; rcv_held = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    since++;
    @(negedge clk);
  endtask

  task automatic send(input int s, input int cnt, input int addr, output msg_t m);
    int exp_ts;
    snd_v[s] = 1'b1; snd_cnt[s] = cnt; snd_addr[s] = addr;
    #1;
    exp_ts = (mclk[s] + 1) & TS_MASK;
    chk("R1 send stamp", snd_ts[s], exp_ts);
    chk("R5 send parity", snd_ep, mep);
    m.s = s; m.cnt = cnt; m.addr = addr; m.ts = exp_ts; m.ep = mep;
    mclk[s] = exp_ts;
    tc = tc - wt(cnt, exp_ts);
    ac = ac - wt(addr, cnt);
    tick();
    clear_in();
  endtask

  task automatic recv(input int d, input msg_t m, input int held);
    bit old, acc, late, over;
    rcv_v[d] = 1'b1; rcv_cnt[d] = m.cnt; rcv_addr[d] = m.addr;
    rcv_ts[d] = m.ts; rcv_ep[d] = m.ep; rcv_held[d] = held;
    old  = (m.ep != mep);
    acc  = old && closing && (since + 1 <= GRACE);
    late = old && !acc;
    over = (held + m.cnt) > TOK_MAX;
    mclk[d] = ((m.ts > mclk[d]) ? m.ts + 1 : mclk[d] + 1) & TS_MASK;
    if (!old) begin
      tc = tc + wt(m.cnt, m.ts);
      ac = ac + wt(m.addr, m.cnt);
    end else if (acc) begin
      to_sig = to_sig + wt(m.cnt, m.ts);
      ao_sig = ao_sig + wt(m.addr, m.cnt);
    end
    tick();
    chk("R7 late flag", late_err[d], late);
    chk("R9 token bound", over_err[d], over);
    clear_in();
  endtask

  // Send and receive on one node in the same cycle (R2 ordering).
  task automatic both(input int n, input int scnt, input int saddr, input msg_t m,
                      output msg_t o);
    int base;
    snd_v[n] = 1'b1; snd_cnt[n] = scnt; snd_addr[n] = saddr;
    rcv_v[n] = 1'b1; rcv_cnt[n] = m.cnt; rcv_addr[n] = m.addr;
    rcv_ts[n] = m.ts; rcv_ep[n] = m.ep; rcv_held[n] = 0;
    #1;
    base = (m.ts > mclk[n]) ? m.ts + 1 : mclk[n] + 1;
    mclk[n] = (base + 1) & TS_MASK;
    chk("R2 same-cycle stamp", snd_ts[n], mclk[n]);
    o.s = n; o.cnt = scnt; o.addr = saddr; o.ts = mclk[n]; o.ep = mep;
    tc = tc + wt(m.cnt, m.ts) - wt(scnt, mclk[n]);
    ac = ac + wt(m.addr, m.cnt) - wt(saddr, scnt);
    tick();
    clear_in();
  endtask

  task automatic close_iv();
    intv_close = 1'b1;
    tick();
    clear_in();
    if (!closing) begin
      closing = 1'b1;
      since   = 0;
      mep     = ~mep;
      to_sig  = tc;
      ao_sig  = ac;
      tc      = '0;
      ac      = '0;
    end
  endtask

  task automatic judge();
    while (since < GRACE + 1) begin
      chk("R6 no early verdict", verdict_v, 0);
      tick();
    end
    chk("R6 verdict timing", verdict_v, 1);
    chk("R3 token verdict", tok_err, to_sig != '0);
    chk("R4 address verdict", adr_err, ao_sig != '0);
    last_tok = (to_sig != '0);
    closing  = 1'b0;
    tick();
    chk("R6 single pulse", verdict_v, 0);
    chk("R11 token flag held", tok_err, last_tok);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin : main
    msg_t m, m2, m3;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) mclk[i] = 0;
    mep = 0; closing = 0; since = 0;
    tc = '0; ac = '0; to_sig = '0; ao_sig = '0; last_tok = 0;
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick(); tick();

    // R10 reset state
    chk("R10 parity after reset", snd_ep, 0);
    chk("R10 verdict after reset", verdict_v, 0);
    chk("R10 token flag after reset", tok_err, 0);
    chk("R10 address flag after reset", adr_err, 0);
    chk("R10 late after reset", late_err, 0);
    chk("R10 over after reset", over_err, 0);
    for (int i = 0; i < N; i++) chk("R10 clock after reset", snd_ts[i], 0);

    // R2 forward jump, then a stale timestamp; unmatched receive -> error verdict
    m.s = 1; m.cnt = 3; m.addr = 12'h05A; m.ts = 200; m.ep = 0;
    recv(0, m, 0);
    send(0, 2, 12'h011, m2);            // expect stamp 202
    chk("R2 jump stamp", m2.ts, 202);
    recv(2, m2, 1);
    m.ts = 5;
    recv(0, m, 0);                      // stale: local goes 202 -> 203
    send(0, 1, 12'h022, m3);
    chk("R2 stale stamp", m3.ts, 204);
    recv(3, m3, 0);
    close_iv();
    judge();
    tick(); tick();
    chk("R11 token flag still held", tok_err, 1);

    // Random intervals with two injected faults
    for (int iv = 0; iv < 6; iv++) begin
      msg_t pend;
      int   n, d;
      bit   have;
      have = 0;
      n = 6 + int'($urandom % 6);
      for (int k = 0; k < n; k++) begin
        msg_t mk;
        int   s, cnt, addr;
        s    = int'($urandom % N);
        d    = (s + 1 + int'($urandom % (N - 1))) % N;
        cnt  = 1 + int'($urandom % TOK_MAX);
        addr = 1 + int'($urandom % ((1 << ADDR_W) - 1));
        send(s, cnt, addr, mk);
        if (iv == 2 && k == 0) mk.cnt = (mk.cnt % TOK_MAX) + 1;
        if (iv == 4 && k == 0) mk.addr = mk.addr ^ 1;
        repeat (int'($urandom % 3)) tick();
        if (k == n - 1) begin
          pend = mk; have = 1; pend.s = d;
        end else begin
          recv(d, mk, int'($urandom % (TOK_MAX - mk.cnt + 1)));
        end
      end
      close_iv();
      repeat (int'($urandom % (GRACE - 1))) tick();
      if (have) recv(pend.s, pend, 0);
      judge();
    end

    // Same-cycle send and receive, token bound edges
    send(1, 4, 12'h100, m);
    both(2, 5, 12'h0F0, m, m2);
    recv(3, m2, TOK_MAX - 5);           // exactly at the limit: no flag
    send(3, 2, 12'h033, m);
    recv(0, m, TOK_MAX - 1);            // one over the limit
    close_iv();
    judge();

    // R8 second close ignored; last counted grace edge accepted
    send(2, 3, 12'h0AB, m);
    close_iv();
    close_iv();
    while (since < GRACE - 1) tick();
    recv(1, m, 0);
    judge();
    repeat (GRACE + 3) begin
      chk("R8 no second verdict", verdict_v, 0);
      tick();
    end
    send(0, 1, 12'h001, m2);            // parity flipped once only
    recv(1, m2, 0);

    // Receive on the first edge past the window: late and missing
    send(3, 2, 12'h0C0, m);
    close_iv();
    while (since < GRACE) tick();
    recv(2, m, 0);
    judge();

    // Late after verdict: not counted in the next interval
    send(1, 6, 12'h0D0, m3);
    close_iv();
    judge();
    recv(0, m3, 0);
    send(2, 1, 12'h0E0, m);
    recv(3, m, 0);
    close_iv();
    judge();
    chk("R7 late receive left out of next interval", tok_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule